// File: doc/BRIEF.md
# Per-DIMM Corrected Error Counter Bank

This block counts corrected memory errors separately for each of the three DIMM slots on one memory channel. The ECC checker sends a single-cycle error pulse together with a two-bit slot index. Each slot has a narrow 15-bit counter that wraps around. Software reads the counters through a small register port that exposes two 32-bit words. Writing zero to a word clears the counters that live in that word.

A poll-side accumulator is attached to the same counters. On each poll strobe it samples all three counters. It subtracts the sample it kept from the previous poll and adds that difference to a 32-bit running total per slot. When the difference is negative, because a counter wrapped in between, the fixed amount 0x7FFF is added to the difference first. The first poll after reset, and the first poll after any clear, only records a new baseline. A flag shows whether the totals are currently tracking.

Top module: `ce_cnt_bank`

## Requirements
- R1: After reset, all three counters, all three totals and `totals_valid` are zero.
- R2: An `err_valid` pulse with `err_dimm` equal to 0, 1 or 2 raises that slot's counter by one, visible in the next cycle. Index 3, or `err_valid` low, leaves every counter unchanged.
- R3: A counter at 0x7FFF that takes one more error reads 0.
- R4: `reg_rdata` is combinational on `reg_addr`. Address 0 returns slot 0 in bits 14:0 and slot 1 in bits 30:16. Address 1 returns slot 2 in bits 14:0. Every other bit reads 0.
- R5: A write (`reg_wr_en`) of data 0 clears only the counters in the addressed word. A write of any nonzero value changes nothing.
- R6: If a clear and an error for the same slot arrive in the same cycle, the counter reads 0 afterwards.
- R7: A poll while `totals_valid` is 0 stores the sampled counters as the baseline, leaves the totals unchanged and sets `totals_valid`.
- R8: A poll while `totals_valid` is 1 adds, for each slot, the sampled count minus the stored sample to that slot's total. The sample taken is the counter value before that cycle's update. The new sample then becomes the stored sample.
- R9: When the sampled count is smaller than the stored sample, the amount added is (sample − stored + 0x7FFF).
- R10: Any clear drops `totals_valid` to 0 and leaves the totals unchanged.
- R11: A poll in the same cycle as a clear has no effect: `totals_valid` stays 0 and the totals are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Corrected-error pulse |
| err_dimm | input | 2 | Slot index of the error |
| reg_addr | input | 1 | Register word select |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| poll | input | 1 | Poll strobe for the accumulator |
| totals_valid | output | 1 | Totals are tracking (a baseline exists) |
| total_dimm0 | output | TOT_W | Running total, slot 0 |
| total_dimm1 | output | TOT_W | Running total, slot 1 |
| total_dimm2 | output | TOT_W | Running total, slot 2 |

## Verification
The bench drives one slot through 32767 errors and checks the counter at 0x7FFF and then at 0. This catches a counter that saturates instead of wrapping.

It also wraps another slot between two polls. The expected total is then short by exactly one count, because 0x7FFF is added rather than 0x8000. A design that takes the difference modulo 2^15, or adds the raw negative value, gives a different total.

Further directed cases cover three things:
- a clear in the same cycle as an error, where a design that lets the increment win shows 1 instead of 0;
- a nonzero write that must not clear anything;
- a poll in the same cycle as a clear, which must not set a baseline. A design that lets the poll win would add a wrong delta on the next poll.

Seeded random traffic then mixes all of these operations against a reference model.

// File: rtl/ce_cnt_pkg.sv
`timescale 1ns/1ps
package ce_cnt_pkg;
  localparam int NUM_DIMMS   = 3;
  localparam int CNT_W       = 15;
  localparam int WORD_W      = 32;
  localparam int SLOT_STRIDE = 16;
  localparam int SLOTS_PER_W = WORD_W / SLOT_STRIDE;
  localparam int NUM_WORDS   = (NUM_DIMMS + SLOTS_PER_W - 1) / SLOTS_PER_W;
  localparam int SEL_W       = $clog2(NUM_DIMMS + 1);
  localparam int ADDR_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/ce_rst_sync.sv
`timescale 1ns/1ps
module ce_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ce_dimm_counter.sv
`timescale 1ns/1ps
module ce_dimm_counter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         clr,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (hit) cnt_d = cnt_q + W'(1);
  end

  assign cnt_en = clr | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R3 is covered as well: the +1 wraps modulo 2^W
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (cnt_q == $past(cnt_q) + W'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/ce_reg_pack.sv
`timescale 1ns/1ps
module ce_reg_pack
  import ce_cnt_pkg::*;
(
  input  cnt_t [NUM_DIMMS-1:0] cnt,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr_en,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_DIMMS-1:0] clr
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  logic [NUM_WORDS-1:0]             clr_word;

  always_comb begin
    words = '0;
    for (int i = 0; i < NUM_DIMMS; i++) begin
      words[i / SLOTS_PER_W][(i % SLOTS_PER_W) * SLOT_STRIDE +: CNT_W] = cnt[i];
    end
  end

  assign reg_rdata = words[reg_addr];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr_word
    assign clr_word[w] = reg_wr_en && (reg_addr == ADDR_W'(w)) && (reg_wdata == '0);
  end

  for (genvar i = 0; i < NUM_DIMMS; i++) begin : g_clr_map
    assign clr[i] = clr_word[i / SLOTS_PER_W];
  end
endmodule

// File: rtl/ce_poll_accum.sv
`timescale 1ns/1ps
module ce_poll_accum #(
  parameter int N     = 3,
  parameter int CW    = 15,
  parameter int TOT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    poll,
  input  logic                    clr_any,
  input  logic [N-1:0][CW-1:0]    sample,
  output logic [N-1:0][TOT_W-1:0] totals_q,
  output logic                    valid_q
);
  localparam logic [CW:0] WRAP_FIX = {1'b0, {CW{1'b1}}};

  logic [N-1:0][CW-1:0]    prev_q, prev_d;
  logic [N-1:0][TOT_W-1:0] totals_d;
  logic [N-1:0][CW-1:0]    delta;
  logic                    valid_d;
  logic                    prev_en, tot_en, valid_en;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [CW:0] diff;
      diff = {1'b0, sample[i]} - {1'b0, prev_q[i]};
      if (diff[CW]) diff = diff + WRAP_FIX;
      delta[i] = diff[CW-1:0];
    end
  end

  always_comb begin
    valid_d  = valid_q;
    prev_d   = prev_q;
    totals_d = totals_q;
    prev_en  = 1'b0;
    tot_en   = 1'b0;
    valid_en = 1'b0;
    if (clr_any) begin
      valid_d  = 1'b0;
      valid_en = 1'b1;
    end else if (poll) begin
      valid_d  = 1'b1;
      valid_en = 1'b1;
      prev_d   = sample;
      prev_en  = 1'b1;
      if (valid_q) begin
        tot_en = 1'b1;
        for (int i = 0; i < N; i++) totals_d[i] = totals_q[i] + TOT_W'(delta[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      prev_q   <= '0;
      totals_q <= '0;
    end else begin
      if (valid_en) valid_q  <= valid_d;
      if (prev_en)  prev_q   <= prev_d;
      if (tot_en)   totals_q <= totals_d;
    end
  end

  assert_baseline_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && !clr_any && !valid_q) |=> (valid_q && $stable(totals_q)));

  assert_clear_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (!valid_q && $stable(totals_q)));

  assert_totals_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll && valid_q) |=> $stable(totals_q));
endmodule

// File: rtl/ce_cnt_bank.sv
`timescale 1ns/1ps
module ce_cnt_bank
  import ce_cnt_pkg::*;
#(
  parameter int TOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [SEL_W-1:0]  err_dimm,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              poll,
  output logic              totals_valid,
  output logic [TOT_W-1:0]  total_dimm0,
  output logic [TOT_W-1:0]  total_dimm1,
  output logic [TOT_W-1:0]  total_dimm2
);
  logic                         rst_n_sync;
  cnt_t [NUM_DIMMS-1:0]         cnt;
  logic [NUM_DIMMS-1:0]         hit;
  logic [NUM_DIMMS-1:0]         clr;
  logic [NUM_DIMMS-1:0][TOT_W-1:0] totals;

  ce_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar i = 0; i < NUM_DIMMS; i++) begin : g_dimm
    assign hit[i] = err_valid && (err_dimm == SEL_W'(i));
    ce_dimm_counter #(.W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .hit   (hit[i]),
      .clr   (clr[i]),
      .cnt_q (cnt[i])
    );
  end

  ce_reg_pack i_reg_pack (
    .cnt       (cnt),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clr       (clr)
  );

  ce_poll_accum #(.N(NUM_DIMMS), .CW(CNT_W), .TOT_W(TOT_W)) i_accum (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .poll     (poll),
    .clr_any  (|clr),
    .sample   (cnt),
    .totals_q (totals),
    .valid_q  (totals_valid)
  );

  assign total_dimm0 = totals[0];
  assign total_dimm1 = totals[1];
  assign total_dimm2 = totals[2];

  assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !reg_rdata[31] && !reg_rdata[15] && ((reg_addr == '0) || (reg_rdata[30:16] == '0)));

  assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0(hit));
endmodule

// File: tb/test_ce_cnt_bank.sv
`timescale 1ns/1ps
module test_ce_cnt_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        err_valid;
  logic [1:0]  err_dimm;
  logic        reg_addr;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        poll;
  logic        totals_valid;
  logic [31:0] total_dimm0, total_dimm1, total_dimm2;

  always #10 clk = ~clk;

  ce_cnt_bank i_ce_cnt_bank (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_dimm(err_dimm),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .poll(poll), .totals_valid(totals_valid),
    .total_dimm0(total_dimm0), .total_dimm1(total_dimm1), .total_dimm2(total_dimm2)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          m_cnt [3];
  int          m_prev [3];
  bit [31:0]   m_tot [3];
  bit          m_valid;

  function automatic int add_amount(int now_v, int old_v);
    int d = now_v - old_v;
    if (d < 0) d = d + 32'h7FFF;
    return d;
  endfunction

  function automatic bit [31:0] word_exp(int addr);
    if (addr == 0) return (32'(m_cnt[1]) << 16) | 32'(m_cnt[0]);
    return 32'(m_cnt[2]);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    err_valid = 0; err_dimm = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0; poll = 0;
  endtask

  task automatic step(bit ev, int idx, bit wr, bit addr, bit [31:0] wd, bit pl);
    int  old [3];
    bit  clr0, clr1;
    err_valid = ev; err_dimm = idx[1:0]; reg_wr_en = wr; reg_addr = addr;
    reg_wdata = wd; poll = pl;
    @(posedge clk);
    old  = m_cnt;
    clr0 = wr && !addr && (wd == 0);
    clr1 = wr && addr && (wd == 0);
    for (int i = 0; i < 3; i++) begin
      if ((i < 2 && clr0) || (i == 2 && clr1)) m_cnt[i] = 0;
      else if (ev && idx == i)                  m_cnt[i] = (m_cnt[i] + 1) % 32768;
    end
    if (clr0 || clr1) m_valid = 0;
    else if (pl) begin
      if (m_valid)
        for (int i = 0; i < 3; i++) m_tot[i] = m_tot[i] + 32'(add_amount(old[i], m_prev[i]));
      m_prev  = old;
      m_valid = 1;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic check_state(string tag);
    reg_addr = 0; #1;
    check({tag, " word0"}, reg_rdata, word_exp(0));
    reg_addr = 1; #1;
    check({tag, " word1"}, reg_rdata, word_exp(1));
    reg_addr = 0;
    check({tag, " total0"}, total_dimm0, m_tot[0]);
    check({tag, " total1"}, total_dimm1, m_tot[1]);
    check({tag, " total2"}, total_dimm2, m_tot[2]);
    check({tag, " valid"}, totals_valid, m_valid);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung run, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4721));
    idle();
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_prev[i] = 0; m_tot[i] = 0; end
    m_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_state("R1 reset");

    // R2: hits per slot, index 3 and idle ignored
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 0);
    for (int k = 0; k < 2; k++) step(1, 2, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    check_state("R2/R4 counts");
    reg_addr = 0; #1;
    check("R4 word0 layout", reg_rdata, 32'h0005_0003);
    reg_addr = 1; #1;
    check("R4 word1 layout", reg_rdata, 32'h0000_0002);
    reg_addr = 0;

    // R7 baseline then R8 delta
    step(0, 0, 0, 0, 0, 1);
    check_state("R7 baseline");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    check_state("R8 delta");
    check("R8 total0 value", total_dimm0, 4);

    // R5 nonzero writes ignored, zero write clears only its word; R10
    step(0, 0, 1, 0, 32'h0000_0001, 0);
    step(0, 0, 1, 1, 32'h8000_0000, 0);
    check_state("R5 nonzero write");
    step(0, 0, 1, 1, 32'h0, 0);
    check_state("R5/R10 clear word1");
    check("R10 valid dropped", totals_valid, 0);

    // R11 poll with clear ignored
    step(1, 1, 0, 0, 0, 1);
    step(0, 0, 1, 1, 32'h0, 1);
    check_state("R11 poll+clear");
    step(0, 0, 0, 0, 0, 1);
    check_state("R7 baseline after clear");

    // R3 wrap of slot 2
    for (int k = 0; k < 32767; k++) step(1, 2, 0, 0, 0, 0);
    reg_addr = 1; #1;
    check("R3 at max", reg_rdata, 32'h0000_7FFF);
    step(1, 2, 0, 0, 0, 0);
    reg_addr = 1; #1;
    check("R3 wrapped", reg_rdata, 32'h0000_0000);
    reg_addr = 0;
    step(0, 0, 0, 0, 0, 1);
    check_state("R9 after slot2 wrap");

    // R9 negative difference: slot 1 passes its old sample
    for (int k = 0; k < 32765; k++) step(1, 1, 0, 0, 0, 0);
    begin
      bit [31:0] before1;
      before1 = m_tot[1];
      step(0, 0, 0, 0, 0, 1);
      check_state("R9 wrap delta");
      check("R9 slot1 added", total_dimm1 - before1, 32764);
    end

    // R6 clear and error in same cycle
    step(1, 0, 1, 0, 32'h0, 0);
    check_state("R6 clear wins");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      int idx = $urandom_range(0, 3);
      bit ev = (r < 70);
      bit pl = (r >= 60 && r < 80) || (r >= 97);
      bit wr = (r >= 92);
      bit ad = $urandom_range(0, 1);
      bit [31:0] wd = ($urandom_range(0, 1) != 0) ? 32'h0 : $urandom;
      step(ev, idx, wr, ad, wd, pl);
      if (k % 10 == 0) check_state("R2/R5/R8/R11 random");
    end
    check_state("R8 random end");

    summary();
    $finish;
  end
endmodule